// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block attaches a byte-wide peripheral to a microcontroller bus whose low address byte and data byte share the same eight wires. The upper address byte arrives on dedicated inputs. The block holds a 16-bit address that follows the bus while the address strobe is high and keeps its value once the strobe falls. It then serves reads and launches writes for that address. Reads are answered on either the instruction-fetch strobe or the data-read strobe, so the same device appears in the host's program space and in its data space.

The device occupies a window of `2^WIN_AW` bytes whose base is set by software through a configuration register at a fixed absolute address. The top `2^REG_AW` bytes of the window are an internal bank of general-purpose byte registers. The rest of the window is forwarded to an external memory array through a simple read port and a one-cycle write strobe. All bus inputs are sampled on `clk`. The pad tristate is built outside the block from `ad_out` and `ad_oe`.

Top module: `mbus_slave`

## Requirements
- R1: The internal address equals `{addr_hi, ad_in}` while `ale` is high. When `ale` falls it holds the last value seen while `ale` was high, whatever the bus lines do afterwards. The low `WIN_AW` bits of this address appear on `mem_raddr`.
- R2: `ad_oe` is high only when `ce_n` is low, the address hits the window or the configuration register, and `psen_n` or `rd_n` is low. Otherwise it is low.
- R3: A read with `psen_n` low returns the same byte as a read with `rd_n` low at the same address.
- R4: An address hits the window when its bits [15:WIN_AW] equal the base. Offsets whose bits [WIN_AW-1:REG_AW] are all ones select register `offset[REG_AW-1:0]`. Any other offset returns `mem_rdata`, with `mem_re` high.
- R5: A write to `CFG_ADDR` loads the base from the low `16-WIN_AW` data bits. A read of `CFG_ADDR` returns the base zero-extended to 8 bits. `CFG_ADDR` takes priority over the window.
- R6: While `rst` is high, the base is cleared to zero, every register in the bank is cleared, and `mem_we` is low.
- R7: After reset, writes to memory or to the register bank have no effect until the configuration register has been written once.
- R8: A write is launched at the clock edge where `wr_n` is first sampled high after being low. The data is the last `ad_in` value sampled with `wr_n` low. For memory targets, `mem_we` is high for exactly the following cycle, with `mem_waddr`/`mem_wdata` carrying the offset and data.
- R9: Each of the `2^REG_AW` bank registers stores a written byte and returns it on a later read.
- R10: While `psen_n`, `rd_n` and `wr_n` are all low, `ad_oe` is low. A write phase that contained such a cycle launches nothing.
- R11: A write phase during which `ce_n` is high launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 8 | Dedicated upper address byte |
| ad_in | input | 8 | Shared address/data lines, input side |
| ale | input | 1 | Address strobe, high while the address is valid |
| ce_n | input | 1 | Chip enable, active low |
| psen_n | input | 1 | Instruction-fetch read strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_out | output | 8 | Read data toward the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| mem_raddr | output | WIN_AW | Memory read offset |
| mem_re | output | 1 | Memory read in progress |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_waddr | output | WIN_AW | Memory write offset |
| mem_wdata | output | 8 | Memory write data |

## Verification
Each of several window bases is swept, including one whose window covers the configuration address. The sweep takes every upper address byte against a set of low bytes, which separates out-of-window misses, memory offsets, register-bank offsets and the configuration register. It also alternates the fetch and data strobes. Directed write cycles cover three separations. Changing the data inside the low phase tells the last sampled byte from the first. Writes before and after configuration tell apart the locked and unlocked states. Writes with chip enable high or with all three strobes low tell ignored cycles from launched ones. An address strobe sequence that changes the lines during and after the strobe tells a transparent latch from a held one.

// File: rtl/mbus_slave.sv
module mbus_slave #(
  parameter int WIN_AW = 13,
  parameter int REG_AW = 4,
  parameter logic [15:0] CFG_ADDR = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        ad_in,
  input  logic              ale,
  input  logic              ce_n,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  output logic [WIN_AW-1:0] mem_raddr,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [WIN_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int BASE_W = 16 - WIN_AW;
  localparam int NREG   = 1 << REG_AW;

  typedef enum logic [1:0] {T_NONE, T_MEM, T_REG, T_CFG} tgt_t;

  logic [15:0]       lat_q, addr;
  logic [BASE_W-1:0] base_q;
  logic              cfg_ok_q;
  logic [7:0]        regs [NREG];
  logic              cfg_hit, win_hit, reg_hit, mem_hit, clash, rd_act;
  logic              wr_q, bad_q, launch;
  logic [7:0]        wd_q;
  logic [WIN_AW-1:0] wa_q;
  tgt_t              tgt_q;

  always_ff @(posedge clk)
    if (rst)      lat_q <= '0;
    else if (ale) lat_q <= {addr_hi, ad_in};

  assign addr    = ale ? {addr_hi, ad_in} : lat_q;
  assign cfg_hit = (addr == CFG_ADDR);
  assign win_hit = !cfg_hit && (addr[15:WIN_AW] == base_q);
  assign reg_hit = win_hit && (&addr[WIN_AW-1:REG_AW]);
  assign mem_hit = win_hit && !reg_hit;
  assign clash   = !psen_n && !rd_n && !wr_n;
  assign rd_act  = !ce_n && (!psen_n || !rd_n) && !clash;

  assign ad_oe     = rd_act && (cfg_hit || win_hit);
  assign mem_re    = rd_act && mem_hit;
  assign mem_raddr = addr[WIN_AW-1:0];
  assign ad_out    = !ad_oe  ? 8'h00 :
                     cfg_hit ? 8'(base_q) :
                     reg_hit ? regs[addr[REG_AW-1:0]] : mem_rdata;

  always_ff @(posedge clk)
    if (rst) begin
      wr_q  <= 1'b1;
      bad_q <= 1'b0;
      tgt_q <= T_NONE;
      wd_q  <= '0;
      wa_q  <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n) begin
        wd_q  <= ad_in;
        wa_q  <= addr[WIN_AW-1:0];
        bad_q <= bad_q | clash;
        tgt_q <= ce_n    ? T_NONE :
                 cfg_hit ? T_CFG  :
                 reg_hit ? T_REG  :
                 mem_hit ? T_MEM  : T_NONE;
      end else begin
        bad_q <= 1'b0;
      end
    end

  assign launch = wr_n && !wr_q && !bad_q;

  always_ff @(posedge clk)
    if (rst) begin
      base_q    <= '0;
      cfg_ok_q  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      mem_we <= launch && cfg_ok_q && (tgt_q == T_MEM);
      if (launch) begin
        mem_waddr <= wa_q;
        mem_wdata <= wd_q;
        if (tgt_q == T_CFG) begin
          base_q   <= wd_q[BASE_W-1:0];
          cfg_ok_q <= 1'b1;
        end
        if (tgt_q == T_REG && cfg_ok_q) regs[wa_q[REG_AW-1:0]] <= wd_q;
      end
    end

  assert_oe_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!ce_n && (!psen_n || !rd_n)));

  assert_base_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !rst) |=> $stable(base_q));

  assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(cfg_ok_q));

  assert_we_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(wr_n) && !$past(wr_n, 2)));

  assert_we_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_clash_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!psen_n && !rd_n && !wr_n) |-> !ad_oe);
endmodule

// File: tb/mbus_slave_bench.sv
module mbus_slave_bench;
  localparam int P = 10;
  localparam int WA = 10;
  localparam logic [15:0] CFG = 16'hFF00;

  logic clk = 0, rst = 1;
  logic [7:0] addr_hi = 0, ad_in = 0;
  logic ale = 0, ce_n = 1, psen_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] ad_out, mem_rdata, mem_wdata;
  logic ad_oe, mem_re, mem_we;
  logic [WA-1:0] mem_raddr, mem_waddr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] regm [16];
  logic [5:0] cur_base = 0;

  always #(P/2) clk = ~clk;

  assign mem_rdata = mem_raddr[7:0] ^ 8'hA5 ^ {6'b0, mem_raddr[9:8]};

  mbus_slave #(.WIN_AW(WA), .REG_AW(4), .CFG_ADDR(CFG)) u_mbus_slave (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_in(ad_in), .ale(ale), .ce_n(ce_n),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .mem_raddr(mem_raddr), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_rd(input logic [15:0] a);
    logic [9:0] off;
    off = a[9:0];
    if (a == CFG) return {1'b1, 2'b00, cur_base};
    if (a[15:10] != cur_base) return 9'h000;
    if (&off[9:4]) return {1'b1, regm[off[3:0]]};
    return {1'b1, off[7:0] ^ 8'hA5 ^ {6'b0, off[9:8]}};
  endfunction

  task automatic do_read(input logic [15:0] a, input bit use_psen, output bit oe, output logic [7:0] d);
    @(negedge clk); addr_hi = a[15:8]; ad_in = a[7:0]; ale = 1;
    @(negedge clk); ale = 0; ad_in = 8'h5A; ce_n = 0;
    if (use_psen) psen_n = 0; else rd_n = 0;
    #(P/4); oe = ad_oe; d = ad_out;
    @(negedge clk); ce_n = 1; psen_n = 1; rd_n = 1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit ce, input bit bad,
                          output bit oe_seen, output bit we, output logic [WA-1:0] wa, output logic [7:0] wd);
    @(negedge clk); addr_hi = a[15:8]; ad_in = a[7:0]; ale = 1;
    @(negedge clk); ale = 0; ce_n = !ce; ad_in = ~d; wr_n = 0;
    if (bad) begin psen_n = 0; rd_n = 0; end
    #(P/4); oe_seen = ad_oe;
    @(negedge clk); ad_in = d;
    @(negedge clk); wr_n = 1; psen_n = 1; rd_n = 1;
    @(negedge clk); we = mem_we; wa = mem_waddr; wd = mem_wdata; ce_n = 1;
  endtask

  task automatic check_read(input logic [15:0] a, input bit use_psen, input string req);
    bit oe; logic [7:0] d; logic [8:0] e;
    e = expect_rd(a);
    do_read(a, use_psen, oe, d);
    chk(oe == e[8], req, $sformatf("oe @%04h", a), oe, e[8]);
    if (e[8]) chk(d == e[7:0], req, $sformatf("data @%04h", a), d, e[7:0]);
  endtask

  task automatic wr_simple(input logic [15:0] a, input logic [7:0] d, output bit we);
    bit oe; logic [WA-1:0] wa; logic [7:0] wd;
    do_write(a, d, 1'b1, 1'b0, oe, we, wa, wd);
  endtask

  initial begin
    bit oe, we, oe2; logic [7:0] d, d2; logic [WA-1:0] wa; logic [7:0] wd;
    for (int i = 0; i < 16; i++) regm[i] = 0;
    repeat (3) @(negedge clk);
    chk(mem_we == 0, "R6", "mem_we in reset", mem_we, 0);
    chk(ad_oe == 0, "R6", "ad_oe in reset", ad_oe, 0);
    rst = 0;

    check_read(CFG, 0, "R6");
    check_read(16'h0005, 0, "R4");
    check_read(16'h03F3, 1, "R6");

    do_write(16'h0010, 8'h77, 1, 0, oe, we, wa, wd);
    chk(we == 0, "R7", "mem write before config", we, 0);
    wr_simple(16'h03F2, 8'h99, we);
    check_read(16'h03F2, 0, "R7");

    wr_simple(CFG, 8'h00, we);
    chk(we == 0, "R5", "cfg write pulses mem_we", we, 0);
    do_write(16'h0010, 8'h77, 1, 0, oe, we, wa, wd);
    chk(we == 1, "R8", "mem_we after rise", we, 1);
    chk(wa == 10'h010, "R8", "mem_waddr", wa, 10'h010);
    chk(wd == 8'h77, "R8", "last low data", wd, 8'h77);
    @(negedge clk);
    chk(mem_we == 0, "R8", "mem_we one cycle", mem_we, 0);

    for (int i = 0; i < 16; i++) begin
      wr_simple(16'h03F0 + 16'(i), 8'(i * 17 + 3), we);
      regm[i] = 8'(i * 17 + 3);
    end
    for (int i = 0; i < 16; i++) check_read(16'h03F0 + 16'(i), i[0], "R9");

    do_read(16'h0123, 1, oe, d);
    do_read(16'h0123, 0, oe2, d2);
    chk(oe && oe2 && d == d2, "R3", "psen vs rd", d, d2);
    chk(d == (8'h23 ^ 8'hA5 ^ 8'h01), "R3", "fetch data", d, 8'h23 ^ 8'hA5 ^ 8'h01);

    @(negedge clk); addr_hi = 8'h01; ad_in = 8'h23; ale = 1;
    @(negedge clk); ale = 0; rd_n = 0; #(P/4);
    chk(ad_oe == 0, "R2", "oe with ce_n high", ad_oe, 0);
    @(negedge clk); rd_n = 1; ce_n = 0; #(P/4);
    chk(ad_oe == 0, "R2", "oe without strobe", ad_oe, 0);
    @(negedge clk); ce_n = 1;

    do_write(16'h0020, 8'h44, 1, 1, oe, we, wa, wd);
    chk(oe == 0, "R10", "oe on clash", oe, 0);
    chk(we == 0, "R10", "write on clash", we, 0);
    do_write(16'h0030, 8'h55, 0, 0, oe, we, wa, wd);
    chk(we == 0, "R11", "write with ce_n high", we, 0);

    @(negedge clk); addr_hi = 8'h01; ad_in = 8'h55; ale = 1; ce_n = 0; rd_n = 0; #(P/4);
    chk(mem_raddr == 10'h155, "R1", "transparent addr", mem_raddr, 10'h155);
    ad_in = 8'h66; #1;
    chk(mem_raddr == 10'h166, "R1", "follows while high", mem_raddr, 10'h166);
    @(negedge clk); ale = 0; ad_in = 8'hEE; addr_hi = 8'h3F; #(P/4);
    chk(mem_raddr == 10'h166 && mem_re, "R1", "held after fall", mem_raddr, 10'h166);
    @(negedge clk); ce_n = 1; rd_n = 1;

    foreach (cur_base[i]) ;
    for (int b = 0; b < 4; b++) begin
      logic [5:0] nb;
      nb = (b == 0) ? 6'd1 : (b == 1) ? 6'd5 : (b == 2) ? 6'd63 : 6'd0;
      wr_simple(CFG, {2'b11, nb}, we);
      cur_base = nb;
      check_read(CFG, 0, "R5");
      for (int hi = 0; hi < 256; hi++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] lo;
          lo = (k == 0) ? 8'h00 : (k == 1) ? 8'h37 : (k == 2) ? 8'hF0 : 8'hFF;
          check_read({8'(hi), lo}, hi[0], "R4");
        end
    end

    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; cur_base = 0;
    for (int i = 0; i < 16; i++) regm[i] = 0;
    check_read(CFG, 0, "R6");
    check_read(16'h03F5, 0, "R6");
    wr_simple(16'h0010, 8'h12, we);
    chk(we == 0, "R7", "locked again after reset", we, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule